// File: doc/BRIEF.md
# External Fault Detection Aggregator

The block raises a security flag for a line differential protection scheme whenever an external fault is likely. Each of the three phases has a DC-offset detection path. Two monitored currents per phase are tested for a large DC component, using fixed-point comparisons against a pickup level and against a fraction of the current's own magnitude. The test also needs a small differential current relative to restraint. Each phase result is then qualified by a power-cycle timer, which steps only on a one-clock cycle strobe.

The qualified phase bits are ORed into a local flag, and that flag goes out to the remote terminals. The bits received from the remote terminals are ORed into a remote flag. A stub-bus mode input decides which flags form the final security output:
- In stub-bus mode the transmitted bit is held low and the remote flag is ignored.
- In normal mode the final output is the local flag OR the remote flag.
- A test mode input forces the final output low.

Upstream logic supplies the current magnitudes and DC components. The settings are static inputs in unsigned Q8.8 per-unit format.

Top module: `efd_aggr`

## Requirements
- R1: For a monitored current, the DC condition is true only when its DC value is strictly greater than its pickup setting and DC*256 is strictly greater than k_dc*magnitude. All values are unsigned Q8.8, with 1.0 pu = 0x0100.
- R2: A phase condition is true when the DC condition of current W or of current X holds, and differential*256 is strictly less than k_rd*restraint.
- R3: The phase condition is sampled only at clock edges where cyc_stb_i is high. A phase bit rises at the third consecutive such edge with the condition true. A strobe with the condition false restarts the count.
- R4: A set phase bit clears at the first strobe edge at which its condition is false.
- R5: efd_loc_o is the OR of the three phase bits, registered one clock after them.
- R6: efd_tx_o equals the local OR one clock later when stub_i is low, and is 0 when stub_i is high.
- R7: efd_rem_o is the OR of all rx_efd_i bits, registered one clock later.
- R8: When test_i is low, efd_o is (local OR remote) if stub_i is low, and local only if stub_i is high. It is registered one clock after its inputs.
- R9: efd_o is 0 one clock after any cycle with test_i high, whatever the other inputs are.
- R10: While rst_ni is low, all outputs and timers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_stb_i | input | 1 | One-clock strobe per power cycle |
| stub_i | input | 1 | Stub-bus mode |
| test_i | input | 1 | Test mode, forces efd_o low |
| mag_w_i | input | 3x16 | Magnitude of current W per phase, Q8.8 |
| dc_w_i | input | 3x16 | DC component of current W per phase, Q8.8 |
| mag_x_i | input | 3x16 | Magnitude of current X per phase, Q8.8 |
| dc_x_i | input | 3x16 | DC component of current X per phase, Q8.8 |
| dif_i | input | 3x16 | Differential magnitude per phase, Q8.8 |
| rsm_i | input | 3x16 | Restraint magnitude per phase, Q8.8 |
| pkp_w_i | input | 16 | DC pickup for current W (default 0x0033) |
| pkp_x_i | input | 16 | DC pickup for current X (default 0x0033) |
| k_dc_i | input | 16 | DC ratio factor (default 0x004D) |
| k_rd_i | input | 16 | Restraint ratio factor (default 0x0080) |
| rx_efd_i | input | N_REM | External-fault bits received from remote terminals |
| ph_efd_o | output | 3 | Qualified phase bits, bit 0 = A, bit 2 = C |
| efd_loc_o | output | 1 | Local external-fault flag |
| efd_tx_o | output | 1 | Bit sent to remote terminals |
| efd_rem_o | output | 1 | Remote external-fault flag |
| efd_o | output | 1 | Final external-fault security flag |

## Verification
The DC path is driven with currents that meet both limits, and with currents that fail only the magnitude ratio, only the pickup, or only the differential-to-restraint limit. This separates each term of the conjunction and shows that either monitored current alone is enough. The timer is driven with a sustained condition, an interrupted one and a release, which separates the three-strobe pickup and the one-strobe dropout from a plain level follower. The combining stage is tried with local only, remote only and both, each under normal mode, stub-bus mode and test mode. This tells the stub gating of the transmitted bit apart from the stub masking of the remote flag and from the test override.

// File: rtl/efd_pkg.sv
package efd_pkg;
  localparam int unsigned N_PH = 3;
  localparam int unsigned Q_W  = 16;
  localparam int unsigned Q_FR = 8;
endpackage

// File: rtl/efd_ratio_cmp.sv
module efd_ratio_cmp #(
  parameter int unsigned DW = 16,
  parameter int unsigned FR = 8
) (
  input  logic [DW-1:0] dc_i,
  input  logic [DW-1:0] mag_i,
  input  logic [DW-1:0] pkp_i,
  input  logic [DW-1:0] k_i,
  output logic          hit_o
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] dc_sc;
  logic [PW-1:0] k_mag;

  // dc > k*mag without division: align dc to the product's fraction
  always_comb begin
    dc_sc = {{DW{1'b0}}, dc_i} << FR;
    k_mag = {{DW{1'b0}}, k_i} * {{DW{1'b0}}, mag_i};
    hit_o = (dc_i > pkp_i) && (dc_sc > k_mag);
  end

  always_comb begin
    if (hit_o) a_r1_above_pickup: assert (dc_i > pkp_i);
  end
endmodule

// File: rtl/efd_qual_timer.sv
module efd_qual_timer #(
  parameter int unsigned PU_CYC = 3,
  parameter int unsigned DO_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic cond_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2((PU_CYC > DO_CYC ? PU_CYC : DO_CYC) + 1);
  localparam logic [CW-1:0] PU_LAST = CW'(PU_CYC - 1);
  localparam logic [CW-1:0] DO_LAST = CW'(DO_CYC - 1);

  logic [CW-1:0] pu_cnt;
  logic [CW-1:0] do_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_cnt <= '0;
      do_cnt <= '0;
      q_o    <= 1'b0;
    end else if (stb_i) begin
      if (cond_i) begin
        do_cnt <= '0;
        if (!q_o) begin
          if (pu_cnt == PU_LAST) begin
            q_o    <= 1'b1;
            pu_cnt <= '0;
          end else begin
            pu_cnt <= pu_cnt + 1'b1;
          end
        end
      end else begin
        pu_cnt <= '0;
        if (q_o) begin
          if (do_cnt == DO_LAST) begin
            q_o    <= 1'b0;
            do_cnt <= '0;
          end else begin
            do_cnt <= do_cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r3_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(q_o));

  a_r3_rise_needs_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !cond_i) |=> !$rose(q_o));

  if (DO_CYC == 1) begin : g_do1
    a_r4_single_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !cond_i) |=> !q_o);
  end
endmodule

// File: rtl/efd_phase.sv
module efd_phase #(
  parameter int unsigned DW     = 16,
  parameter int unsigned FR     = 8,
  parameter int unsigned PU_CYC = 3,
  parameter int unsigned DO_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [DW-1:0] mag_w_i,
  input  logic [DW-1:0] dc_w_i,
  input  logic [DW-1:0] mag_x_i,
  input  logic [DW-1:0] dc_x_i,
  input  logic [DW-1:0] dif_i,
  input  logic [DW-1:0] rsm_i,
  input  logic [DW-1:0] pkp_w_i,
  input  logic [DW-1:0] pkp_x_i,
  input  logic [DW-1:0] k_dc_i,
  input  logic [DW-1:0] k_rd_i,
  output logic          efd_o
);
  localparam int unsigned PW = 2 * DW;

  logic          hit_w, hit_x, low_dif, cond;
  logic [PW-1:0] dif_sc, k_rsm;

  efd_ratio_cmp #(.DW(DW), .FR(FR)) u_cmp_w (
    .dc_i(dc_w_i), .mag_i(mag_w_i), .pkp_i(pkp_w_i), .k_i(k_dc_i), .hit_o(hit_w)
  );

  efd_ratio_cmp #(.DW(DW), .FR(FR)) u_cmp_x (
    .dc_i(dc_x_i), .mag_i(mag_x_i), .pkp_i(pkp_x_i), .k_i(k_dc_i), .hit_o(hit_x)
  );

  // external-fault signature: little differential relative to restraint
  always_comb begin
    dif_sc  = {{DW{1'b0}}, dif_i} << FR;
    k_rsm   = {{DW{1'b0}}, k_rd_i} * {{DW{1'b0}}, rsm_i};
    low_dif = dif_sc < k_rsm;
    cond    = (hit_w || hit_x) && low_dif;
  end

  efd_qual_timer #(.PU_CYC(PU_CYC), .DO_CYC(DO_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_i), .cond_i(cond), .q_o(efd_o)
  );

  a_r2_no_pick_on_high_dif: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !low_dif) |=> !$rose(efd_o));
endmodule

// File: rtl/efd_aggr.sv
module efd_aggr
  import efd_pkg::*;
#(
  parameter int unsigned N_REM  = 2,
  parameter int unsigned PU_CYC = 3,
  parameter int unsigned DO_CYC = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cyc_stb_i,
  input  logic                      stub_i,
  input  logic                      test_i,
  input  logic [N_PH-1:0][Q_W-1:0]  mag_w_i,
  input  logic [N_PH-1:0][Q_W-1:0]  dc_w_i,
  input  logic [N_PH-1:0][Q_W-1:0]  mag_x_i,
  input  logic [N_PH-1:0][Q_W-1:0]  dc_x_i,
  input  logic [N_PH-1:0][Q_W-1:0]  dif_i,
  input  logic [N_PH-1:0][Q_W-1:0]  rsm_i,
  input  logic [Q_W-1:0]            pkp_w_i,
  input  logic [Q_W-1:0]            pkp_x_i,
  input  logic [Q_W-1:0]            k_dc_i,
  input  logic [Q_W-1:0]            k_rd_i,
  input  logic [N_REM-1:0]          rx_efd_i,
  output logic [N_PH-1:0]           ph_efd_o,
  output logic                      efd_loc_o,
  output logic                      efd_tx_o,
  output logic                      efd_rem_o,
  output logic                      efd_o
);
  logic loc_any, rem_any;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    efd_phase #(.DW(Q_W), .FR(Q_FR), .PU_CYC(PU_CYC), .DO_CYC(DO_CYC)) u_ph (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stb_i   (cyc_stb_i),
      .mag_w_i (mag_w_i[p]),
      .dc_w_i  (dc_w_i[p]),
      .mag_x_i (mag_x_i[p]),
      .dc_x_i  (dc_x_i[p]),
      .dif_i   (dif_i[p]),
      .rsm_i   (rsm_i[p]),
      .pkp_w_i (pkp_w_i),
      .pkp_x_i (pkp_x_i),
      .k_dc_i  (k_dc_i),
      .k_rd_i  (k_rd_i),
      .efd_o   (ph_efd_o[p])
    );
  end

  assign loc_any = |ph_efd_o;
  assign rem_any = |rx_efd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      efd_loc_o <= 1'b0;
      efd_tx_o  <= 1'b0;
      efd_rem_o <= 1'b0;
      efd_o     <= 1'b0;
    end else begin
      efd_loc_o <= loc_any;
      efd_tx_o  <= loc_any && !stub_i;
      efd_rem_o <= rem_any;
      // stub bus: remote zone is not ours; test: drop the extra security
      if (test_i)      efd_o <= 1'b0;
      else if (stub_i) efd_o <= loc_any;
      else             efd_o <= loc_any || rem_any;
    end
  end

  a_r5_local_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ph_efd_o) |=> efd_loc_o);

  a_r6_tx_blocked_in_stub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stub_i |=> !efd_tx_o);

  a_r7_remote_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_efd_i) |=> efd_rem_o);

  a_r8_remote_masked_in_stub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stub_i && !(|ph_efd_o)) |=> !efd_o);

  a_r8_remote_sets_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stub_i && !test_i && (|rx_efd_i)) |=> efd_o);

  a_r9_test_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> !efd_o);
endmodule

// File: tb/efd_aggr_bench.sv
module efd_aggr_bench;
  localparam int unsigned NR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, stub = 1'b0, test = 1'b0;
  logic [2:0][15:0] mag_w, dc_w, mag_x, dc_x, dif, rsm;
  logic [15:0] pkp_w = 16'h0033, pkp_x = 16'h0033, k_dc = 16'h004D, k_rd = 16'h0080;
  logic [NR-1:0] rx = '0;
  logic [2:0] ph;
  logic loc, tx, rem, efd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  efd_aggr #(.N_REM(NR)) u_efd_aggr (
    .clk_i(clk), .rst_ni(rst_n), .cyc_stb_i(stb), .stub_i(stub), .test_i(test),
    .mag_w_i(mag_w), .dc_w_i(dc_w), .mag_x_i(mag_x), .dc_x_i(dc_x),
    .dif_i(dif), .rsm_i(rsm), .pkp_w_i(pkp_w), .pkp_x_i(pkp_x),
    .k_dc_i(k_dc), .k_rd_i(k_rd), .rx_efd_i(rx),
    .ph_efd_o(ph), .efd_loc_o(loc), .efd_tx_o(tx), .efd_rem_o(rem), .efd_o(efd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic quiet_all();
    for (int p = 0; p < 3; p++) begin
      mag_w[p] = 16'h0; dc_w[p] = 16'h0; mag_x[p] = 16'h0; dc_x[p] = 16'h0;
      dif[p] = 16'h0; rsm[p] = 16'h0100;
    end
  endtask

  // 1.0 pu DC on 2.0 pu magnitude: 0x10000 > 77*512, and 0x100 > 0x33
  task automatic set_w(input int p);
    dc_w[p] = 16'h0100; mag_w[p] = 16'h0200;
  endtask

  task automatic clear_and_idle();
    quiet_all(); stub = 1'b0; test = 1'b0; rx = '0;
    strobe(); strobe(); settle(); settle();
  endtask

  task automatic t_reset();
    chk("R10 ph", {5'b0, ph}, 8'h0);
    chk("R10 flags", {4'b0, loc, tx, rem, efd}, 8'h0);
  endtask

  task automatic t_pickup_dropout();
    quiet_all(); set_w(0);
    strobe(); strobe();
    chk("R3 no bit after 2 strobes", {5'b0, ph}, 8'h0);
    strobe();
    chk("R3 bit after 3 strobes", {5'b0, ph}, 8'h1);
    settle();
    chk("R5 local", {7'b0, loc}, 8'h1);
    chk("R6 tx normal", {7'b0, tx}, 8'h1);
    chk("R8 final local", {7'b0, efd}, 8'h1);
    quiet_all();
    settle(); settle();
    chk("R3 held without strobe", {5'b0, ph}, 8'h1);
    strobe();
    chk("R4 drop after 1 strobe", {5'b0, ph}, 8'h0);
    settle();
    chk("R5 local clear", {7'b0, loc}, 8'h0);
  endtask

  task automatic t_interrupted();
    quiet_all(); set_w(1);
    strobe(); strobe();
    quiet_all(); strobe();
    set_w(1); strobe(); strobe();
    chk("R3 restart after gap", {5'b0, ph}, 8'h0);
    strobe();
    chk("R3 bit after restart", {5'b0, ph}, 8'h2);
    clear_and_idle();
  endtask

  task automatic t_limits();
    // fails ratio only: 77*0x400 = 78848 > 65536
    quiet_all(); dc_w[0] = 16'h0100; mag_w[0] = 16'h0400;
    strobe(); strobe(); strobe(); strobe();
    chk("R1 ratio blocks", {5'b0, ph}, 8'h0);
    // fails pickup only: 0x30 < 0x33
    quiet_all(); dc_w[0] = 16'h0030; mag_w[0] = 16'h0000;
    strobe(); strobe(); strobe(); strobe();
    chk("R1 pickup blocks", {5'b0, ph}, 8'h0);
    // fails differential only: 0x10000 not < 0x80*0x100
    quiet_all(); set_w(0); dif[0] = 16'h0100;
    strobe(); strobe(); strobe(); strobe();
    chk("R2 differential blocks", {5'b0, ph}, 8'h0);
    // current X alone on phase C
    quiet_all(); dc_x[2] = 16'h0100; mag_x[2] = 16'h0200;
    strobe(); strobe(); strobe();
    chk("R2 X path picks", {5'b0, ph}, 8'h4);
    clear_and_idle();
  endtask

  task automatic t_modes();
    // remote only, normal
    rx = 2'b10; settle();
    chk("R7 remote or", {7'b0, rem}, 8'h1);
    chk("R8 remote sets final", {7'b0, efd}, 8'h1);
    chk("R6 tx no local", {7'b0, tx}, 8'h0);
    // remote only, stub
    stub = 1'b1; settle();
    chk("R8 stub masks remote", {7'b0, efd}, 8'h0);
    chk("R7 remote still shown", {7'b0, rem}, 8'h1);
    // local plus remote, stub
    quiet_all(); set_w(1); strobe(); strobe(); strobe(); settle();
    chk("R6 tx blocked stub", {7'b0, tx}, 8'h0);
    chk("R8 stub local", {7'b0, efd}, 8'h1);
    // test override
    test = 1'b1; settle();
    chk("R9 test low stub", {7'b0, efd}, 8'h0);
    stub = 1'b0; settle();
    chk("R9 test low normal", {7'b0, efd}, 8'h0);
    chk("R5 local under test", {7'b0, loc}, 8'h1);
    test = 1'b0; settle();
    chk("R8 final after test", {7'b0, efd}, 8'h1);
    chk("R6 tx normal again", {7'b0, tx}, 8'h1);
    rx = 2'b00; settle();
    chk("R7 remote clear", {7'b0, rem}, 8'h0);
    clear_and_idle();
    chk("R8 all clear", {7'b0, efd}, 8'h0);
  endtask

  initial begin
    quiet_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_pickup_dropout();
    t_interrupted();
    t_limits();
    t_modes();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule